// File: doc/BRIEF.md
# Circular Operand-Stack Cache with Background Dribbler

This block keeps the top of a stack processor's operand stack in a ring of on-chip registers. The pipeline pushes results, pops operands and reads the two topmost words every cycle. A push together with a pop in the same cycle replaces the top word, which is how the last pipeline stage writes a result back onto the stack. The ring is addressed by a bottom index plus an occupancy count, so every index arithmetic step wraps modulo the number of slots.

A dribbler moves words between the ring and data memory while the pipeline runs. When too many words are cached, it writes the oldest word out. When too few are cached and memory still holds words beneath the cached bottom, it reads the next one back in. Each transfer is one word through a request/acknowledge port. The pipeline only sees a stall when it pushes into a completely full ring or pops from an empty one.

The word address of the cached bottom entry is tracked. It is loaded from a stack-base input at reset, so the block can tell when memory holds nothing below the ring.

Top module: `stack_cache`

## Requirements
- R1: A push stores a word that appears on `top0_o` after the clock edge, and the previous top moves to `top1_o`. A pop removes the top word. Word order over any sequence is last-in first-out, whether the words sit in the ring or have gone through memory.
- R2: Asserting push and pop together with at least one word cached overwrites the top word with `push_data_i` and leaves the total stack depth unchanged. This also holds when the ring is full.
- R3: `count_o` never exceeds 64. A push without a pop while 64 words are cached raises `stall_o` and is not performed.
- R4: A pop, or a push together with a pop, while `count_o` is 0 raises `stall_o` and changes nothing.
- R5: While `count_o` exceeds the high mark (48), the block requests a write (`mem_we_o`=1) of the bottom cached word to the bottom's memory address. Each acknowledged write raises that address by one. With the pipeline idle, the count settles at exactly 48. The first spilled word goes to `stack_base_i`.
- R6: While `count_o` is below the low mark (16) and memory holds words below the ring, the block requests a read (`mem_we_o`=0) at bottom address minus one. The acknowledged data becomes the new bottom entry. With the pipeline idle, the count settles at no less than min(16, total depth).
- R7: No read is requested while the bottom address equals the stack-base value latched at reset.
- R8: At most one memory word is requested per cycle. Without `mem_ack_i`, the request stays pending and the cached count does not move unless the pipeline pushes or pops.
- R9: After reset, `count_o` is 0, `stall_o` is 0 and `mem_req_o` is 0.
- R10: `stall_o` is never high while `count_o` lies strictly between 0 and 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stack_base_i | input | 16 | Word address of the stack floor in memory, latched at reset |
| push_i | input | 1 | Push `push_data_i` (with `pop_i`: replace the top) |
| pop_i | input | 1 | Pop the top word |
| push_data_i | input | 32 | Word to push or write over the top |
| top0_o | output | 32 | Top word (valid when `count_o` >= 1) |
| top1_o | output | 32 | Word beneath the top (valid when `count_o` >= 2) |
| count_o | output | 7 | Number of words cached in the ring |
| stall_o | output | 1 | Requested operation cannot be performed this cycle |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | 1 for a spill write, 0 for a fill read |
| mem_addr_o | output | 16 | Word address of the request |
| mem_wdata_o | output | 32 | Data for a spill write |
| mem_ack_i | input | 1 | Request completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid in the acknowledged cycle |

## Verification
The checks assume that `stack_base_i` is held constant after reset, and that `mem_rdata_i` returns what was last written at the requested address. The bench enforces both: it ties the base to one value and answers reads from its own memory array, which is updated on each acknowledged write. The checks also assume the pipeline retries a stalled operation instead of dropping it. Every bench operation holds its inputs until `stall_o` falls. The bench never pops an empty stack when memory is also empty, because that wait would never end.

// File: rtl/sc_pkg.sv
package sc_pkg;

    // Transfer chosen by the dribbler for the current cycle
    typedef enum logic [1:0] {
        DRB_IDLE  = 2'd0,
        DRB_SPILL = 2'd1,
        DRB_FILL  = 2'd2
    } drb_op_e;

endpackage

// File: rtl/sc_ring.sv
module sc_ring #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    // pipeline write port (push or replace)
    input  logic          wa_en,
    input  logic [IW-1:0] wa_idx,
    input  logic [W-1:0]  wa_data,
    // dribbler write port (fill)
    input  logic          wb_en,
    input  logic [IW-1:0] wb_idx,
    input  logic [W-1:0]  wb_data,
    // read ports
    input  logic [IW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  rb_data,
    input  logic [IW-1:0] rc_idx,
    output logic [W-1:0]  rc_data
);

    logic [W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wa_en && (wa_idx == IW'(g))) begin
                slot_q[g] <= wa_data;
            end else if (wb_en && (wb_idx == IW'(g))) begin
                slot_q[g] <= wb_data;
            end
        end
    end

    assign ra_data = slot_q[ra_idx];
    assign rb_data = slot_q[rb_idx];
    assign rc_data = slot_q[rc_idx];

endmodule

// File: rtl/sc_dribbler.sv
module sc_dribbler
    import sc_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 16,
    parameter int HI    = 48,
    parameter int LO    = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] cnt,
    input  logic [AW-1:0] bot_addr,
    input  logic [AW-1:0] floor_addr,
    output drb_op_e       op,
    output logic [AW-1:0] req_addr
);

    localparam logic [CW-1:0] HI_C = CW'(HI);
    localparam logic [CW-1:0] LO_C = CW'(LO);

    logic spill_need;
    logic fill_need;

    // spill has priority; the marks keep the two ranges disjoint
    assign spill_need = (cnt > HI_C);
    assign fill_need  = (cnt < LO_C) && (bot_addr != floor_addr);

    always_comb begin
        op       = DRB_IDLE;
        req_addr = bot_addr;
        if (spill_need) begin
            op       = DRB_SPILL;
            req_addr = bot_addr;
        end else if (fill_need) begin
            op       = DRB_FILL;
            req_addr = bot_addr - AW'(1);
        end
    end

endmodule

// File: rtl/stack_cache.sv
module stack_cache
    import sc_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    parameter int AW    = 16,
    parameter int HI    = 48,
    parameter int LO    = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] stack_base_i,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [W-1:0]  push_data_i,
    output logic [W-1:0]  top0_o,
    output logic [W-1:0]  top1_o,
    output logic [CW-1:0] count_o,
    output logic          stall_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [W-1:0]  mem_wdata_o,
    input  logic          mem_ack_i,
    input  logic [W-1:0]  mem_rdata_i
);

    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    typedef struct packed {
        logic [IW-1:0] bot;
        logic [CW-1:0] cnt;
        logic [AW-1:0] baddr;
        logic [AW-1:0] floor;
    } state_t;

    state_t st_q, st_d;

    drb_op_e       drb_op;
    logic [AW-1:0] drb_addr;
    logic [IW-1:0] top_idx;
    logic [IW-1:0] below_idx;
    logic [IW-1:0] push_idx;
    logic [IW-1:0] fill_idx;
    logic [W-1:0]  bot_word;
    logic          do_push, do_pop, do_repl;
    logic          spill_done, fill_done;
    logic          wa_en;
    logic [IW-1:0] wa_idx;

    sc_dribbler #(
        .DEPTH(DEPTH), .AW(AW), .HI(HI), .LO(LO)
    ) i_drb (
        .cnt        (st_q.cnt),
        .bot_addr   (st_q.baddr),
        .floor_addr (st_q.floor),
        .op         (drb_op),
        .req_addr   (drb_addr)
    );

    // ring index arithmetic wraps on IW bits
    assign push_idx  = st_q.bot + st_q.cnt[IW-1:0];
    assign top_idx   = push_idx - IW'(1);
    assign below_idx = push_idx - IW'(2);
    assign fill_idx  = st_q.bot - IW'(1);

    assign do_push = push_i && !pop_i && (st_q.cnt != FULL_C);
    assign do_pop  = pop_i && !push_i && (st_q.cnt != '0);
    assign do_repl = push_i && pop_i && (st_q.cnt != '0);

    assign stall_o = (push_i && !pop_i && (st_q.cnt == FULL_C))
                   || (pop_i && (st_q.cnt == '0));

    assign mem_req_o   = (drb_op != DRB_IDLE);
    assign mem_we_o    = (drb_op == DRB_SPILL);
    assign mem_addr_o  = drb_addr;
    assign mem_wdata_o = bot_word;

    assign spill_done = (drb_op == DRB_SPILL) && mem_ack_i;
    assign fill_done  = (drb_op == DRB_FILL) && mem_ack_i;

    assign wa_en  = do_push || do_repl;
    assign wa_idx = do_repl ? top_idx : push_idx;

    sc_ring #(
        .W(W), .DEPTH(DEPTH)
    ) i_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wa_en   (wa_en),
        .wa_idx  (wa_idx),
        .wa_data (push_data_i),
        .wb_en   (fill_done),
        .wb_idx  (fill_idx),
        .wb_data (mem_rdata_i),
        .ra_idx  (top_idx),
        .ra_data (top0_o),
        .rb_idx  (below_idx),
        .rb_data (top1_o),
        .rc_idx  (st_q.bot),
        .rc_data (bot_word)
    );

    always_comb begin
        st_d = st_q;
        st_d.cnt = st_q.cnt
                 + (do_push   ? CW'(1) : CW'(0))
                 - (do_pop    ? CW'(1) : CW'(0))
                 + (fill_done ? CW'(1) : CW'(0))
                 - (spill_done ? CW'(1) : CW'(0));
        if (spill_done) begin
            st_d.bot   = st_q.bot + IW'(1);
            st_d.baddr = st_q.baddr + AW'(1);
        end else if (fill_done) begin
            st_d.bot   = st_q.bot - IW'(1);
            st_d.baddr = st_q.baddr - AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bot   <= '0;
            st_q.cnt   <= '0;
            st_q.baddr <= stack_base_i;
            st_q.floor <= stack_base_i;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

endmodule

// File: rtl/sc_checker.sv
module sc_checker #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    parameter int AW    = 16,
    parameter int HI    = 48,
    parameter int LO    = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] stack_base_i,
    input logic          push_i,
    input logic          pop_i,
    input logic [W-1:0]  push_data_i,
    input logic [W-1:0]  top0_o,
    input logic [CW-1:0] count_o,
    input logic          stall_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_ack_i
);

    logic txn;
    assign txn = mem_req_o && mem_ack_i;

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH));

    a_r10_stall_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o > 0 && count_o < CW'(DEPTH)) |-> !stall_o);

    a_r5_spill_above_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> count_o > CW'(HI));

    a_r6_fill_below_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o) |-> count_o < CW'(LO));

    a_r7_fill_above_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o) |-> mem_addr_o >= stack_base_i);

    a_r8_wait_for_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i && !push_i && !pop_i) |=> $stable(count_o));

    a_r1_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !stall_o && !txn) |=> count_o == $past(count_o) - CW'(1));

    a_r1_push_on_top: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !stall_o) |=> top0_o == $past(push_data_i));

    a_r2_replace_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !stall_o && !txn) |=> $stable(count_o));

endmodule

bind stack_cache sc_checker #(
    .W(W), .DEPTH(DEPTH), .AW(AW), .HI(HI), .LO(LO)
) i_sc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .stack_base_i (stack_base_i),
    .push_i       (push_i),
    .pop_i        (pop_i),
    .push_data_i  (push_data_i),
    .top0_o       (top0_o),
    .count_o      (count_o),
    .stall_o      (stall_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_ack_i    (mem_ack_i)
);

// File: tb/test_stack_cache.sv
module test_stack_cache;

    localparam int W    = 32;
    localparam int AW   = 16;
    localparam int CW   = 7;
    localparam logic [AW-1:0] BASE = 16'h0010;
    localparam int NVEC = 16;

    // {push, pop, data}
    localparam logic [33:0] VEC [NVEC] = '{
        {2'b10, 32'h0000_0011}, {2'b10, 32'h0000_0022}, {2'b10, 32'h0000_0033},
        {2'b11, 32'h0000_0044}, {2'b01, 32'h0000_0000}, {2'b10, 32'h0000_0055},
        {2'b10, 32'h0000_0066}, {2'b01, 32'h0000_0000}, {2'b01, 32'h0000_0000},
        {2'b11, 32'h0000_0077}, {2'b10, 32'h0000_0088}, {2'b10, 32'h0000_0099},
        {2'b01, 32'h0000_0000}, {2'b11, 32'h0000_00AA}, {2'b01, 32'h0000_0000},
        {2'b01, 32'h0000_0000}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          push_i, pop_i;
    logic [W-1:0]  push_data_i;
    logic [W-1:0]  top0_o, top1_o;
    logic [CW-1:0] count_o;
    logic          stall_o;
    logic          mem_req_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [W-1:0]  mem_wdata_o;
    logic          mem_ack_i;
    logic [W-1:0]  mem_rdata_i;

    logic [W-1:0]  mem [256];
    logic [W-1:0]  mdl [512];
    int            depth;
    int            n_chk = 0;
    int            n_bad = 0;
    int            cyc = 0;
    bit            done = 1'b0;

    always #5 clk = ~clk;

    stack_cache i_stack_cache (
        .clk, .rst_n, .stack_base_i(BASE), .push_i, .pop_i, .push_data_i,
        .top0_o, .top1_o, .count_o, .stall_o, .mem_req_o, .mem_we_o,
        .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i
    );

    assign mem_rdata_i = mem[mem_addr_o[7:0]];
    always @(posedge clk) begin
        if (mem_req_o && mem_ack_i && mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        push_i = 0; pop_i = 0; push_data_i = '0; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        depth = 0;
        @(negedge clk);
    endtask

    task automatic do_op(input bit p, input bit q, input logic [W-1:0] d);
        push_i = p; pop_i = q; push_data_i = d;
        #1;
        while (stall_o) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        push_i = 0; pop_i = 0;
        if (p && q) mdl[depth-1] = d;
        else if (p) begin mdl[depth] = d; depth++; end
        else depth--;
        #1;
    endtask

    task automatic check_tops(input string req);
        if (depth >= 1) check(top0_o == mdl[depth-1], req, top0_o, mdl[depth-1]);
        if (depth >= 2) check(top1_o == mdl[depth-2], req, top1_o, mdl[depth-2]);
    endtask

    initial begin
        mem_ack_i = 1;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        do_reset();

        // R9 reset state
        check(count_o == 0, "R9 count", 64'(count_o), 0);
        check(stall_o == 0, "R9 stall", 64'(stall_o), 0);
        check(mem_req_o == 0, "R9 req", 64'(mem_req_o), 0);

        // R4 / R7: pop on an empty stack with empty memory
        pop_i = 1; #1;
        check(stall_o == 1, "R4 pop empty stall", 64'(stall_o), 1);
        check(mem_req_o == 0, "R7 no fill at floor", 64'(mem_req_o), 0);
        @(negedge clk);
        check(count_o == 0, "R4 count unchanged", 64'(count_o), 0);
        pop_i = 0; #1;

        // R1 / R2: vector table
        for (int v = 0; v < NVEC; v++) begin
            do_op(VEC[v][33], VEC[v][32], VEC[v][31:0]);
            check_tops(VEC[v][33] && VEC[v][32] ? "R2 replace top" : "R1 lifo top");
        end

        // R5 / R6 / R7: deep stack through memory
        do_reset();
        for (int i = 0; i < 100; i++) do_op(1, 0, 32'hA000_0000 + i);
        repeat (100) @(negedge clk);
        #1;
        check(count_o == 48, "R5 settles at high mark", 64'(count_o), 48);
        check(mem[BASE] == 32'hA000_0000, "R5 first spill at base", mem[BASE], 32'hA000_0000);
        check(mem[BASE+51] == 32'hA000_0033, "R5 spill order", mem[BASE+51], 32'hA000_0033);
        for (int i = 0; i < 80; i++) begin
            do_op(0, 1, '0);
            check_tops("R6 lifo through fill");
        end
        repeat (60) @(negedge clk);
        #1;
        check(count_o >= 16, "R6 refilled to low mark", 64'(count_o), 16);
        for (int i = 0; i < 10; i++) do_op(0, 1, '0);
        check_tops("R6 lifo after refill");
        repeat (60) @(negedge clk);
        #1;
        check(count_o == 10, "R6 all words back", 64'(count_o), 10);
        check(mem_req_o == 0, "R7 idle at floor", 64'(mem_req_o), 0);

        // R3 / R8 / R2: full ring with memory not answering
        mem_ack_i = 0;
        do_reset();
        for (int i = 0; i < 64; i++) do_op(1, 0, 32'hB000_0000 + i);
        check(count_o == 64, "R3 ring full", 64'(count_o), 64);
        push_i = 1; push_data_i = 32'hDEAD_BEEF; #1;
        check(stall_o == 1, "R3 push full stalls", 64'(stall_o), 1);
        check(mem_req_o && mem_we_o, "R8 spill pending", {mem_req_o, mem_we_o}, 2'b11);
        check(mem_addr_o == BASE, "R5 spill address", 64'(mem_addr_o), 64'(BASE));
        repeat (5) @(negedge clk);
        push_i = 0; #1;
        check(count_o == 64, "R8 no progress without ack", 64'(count_o), 64);
        check(top0_o == 32'hB000_003F, "R3 stalled push dropped", top0_o, 32'hB000_003F);
        do_op(1, 1, 32'hC0DE_0001);
        check(count_o == 64, "R2 replace keeps count", 64'(count_o), 64);
        check_tops("R2 replace at full");
        mem_ack_i = 1;
        do_op(1, 0, 32'hC0DE_0002);
        check_tops("R3 push after room made");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule